// File: doc/BRIEF.md
# Boot-Time Configuration Stream Sequencer

After reset this block reads configuration bytes one at a time from a serial EEPROM reader and writes each byte into the device register file. The register-file address of each write is the EEPROM address the byte came from. With no software involvement it starts at EEPROM address 0000h and walks upward one byte per read.

Software can redirect or stop the stream at run time. It does this through a small host register port that holds three command bits.

- Stop ends all further reads until the next reset.
- Redirect moves the next read to a programmable 16-bit address.
- Select moves the next read to an entry in an eight-entry start-address table. The entry is chosen by a 3-bit board index that is sampled from DIP switches just after reset.

The EEPROM side is a plain request/valid byte interface. The serial protocol behind it is not part of this block.

Top module: `cfg_loader`

## Requirements
- R1: After reset the first EEPROM request is at address 0000h. The board index is captured from `dip_sw` on the first clock after the internal reset release. Later changes on `dip_sw` do not change it.
- R2: `ee_req` stays high with `ee_addr` stable until a cycle in which `ee_valid` is high. Each request consumes exactly one byte.
- R3: A byte taken with `ee_valid` appears in the next cycle as a single-cycle `rf_we`. In that cycle `rf_addr` equals the EEPROM address of the byte and `rf_wdata` equals the byte. The next request is raised only after that write cycle.
- R4: With no command pending, the next read address is the previous address plus one. It wraps from FFFFh to 0000h.
- R5: Writing 1 to command bit 2 (host address 42h) makes the next read use the redirect address. The high byte of that address is at host address 40h and the low byte is at 41h.
- R6: Writing 1 to command bit 1 makes the next read use start-table entry k, where k is the captured board index. Entry k has its high byte at host address 50h+2k and its low byte at 51h+2k.
- R7: Writing 1 to command bit 0 lets the outstanding read finish and be written. After that no request is raised until reset, and bit 0 reads back 1 from then on.
- R8: Command bits are write-one-to-set and all are acted on at the write of the current byte. Stop wins over redirect, and redirect wins over select. Bits 2 and 1 read back 0 once acted on. The command register reads as {5'b0, bit2, bit1, bit0}.
- R9: Host address 43h reads {5'b0, index} and cannot be written. Unmapped host addresses read 00h. Writes to command bits 7:3 have no effect on the stream or on the read-back value.
- R10: The redirect bytes and every start-table byte read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dip_sw | input | IW | Board index switches |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational from host_addr) |
| ee_req | output | 1 | EEPROM byte read request |
| ee_addr | output | 16 | EEPROM byte address |
| ee_valid | input | 1 | EEPROM byte valid pulse |
| ee_data | input | 8 | EEPROM byte |
| rf_we | output | 1 | Register-file write strobe |
| rf_addr | output | 16 | Register-file write address |
| rf_wdata | output | 8 | Register-file write data |

## Verification
The bench drives several cases where a wrong design behaves visibly differently:

- Redirect and select are written together. A design with the priority reversed lands on the table entry instead of the redirect address.
- The stream is redirected to FFFFh and must wrap to 0000h. A design that saturates or extends the address would read the wrong location.
- `dip_sw` is changed after the index is captured. A design that samples it continuously would pick a different table entry.
- Stop is issued while a read is outstanding. A design that drops the pending byte would lose one write. A design that keeps requesting after stop would show `ee_req` high.
- Reserved command bits are written. A design that leaked them into the stream would alter the next address.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  localparam int AW = 16;
  localparam int DW = 8;
  localparam int HAW = 8;

  localparam logic [HAW-1:0] HA_RDIR_HI = 8'h40;
  localparam logic [HAW-1:0] HA_RDIR_LO = 8'h41;
  localparam logic [HAW-1:0] HA_CMD     = 8'h42;
  localparam logic [HAW-1:0] HA_INDEX   = 8'h43;
  localparam logic [HAW-1:0] HA_TABLE   = 8'h50;

  localparam int CB_STOP   = 0;
  localparam int CB_SELECT = 1;
  localparam int CB_RDIR   = 2;

  typedef enum logic [1:0] {
    ST_BOOT,
    ST_REQ,
    ST_WR,
    ST_STOP
  } seq_state_e;

endpackage

// File: rtl/cfg_loader_regs.sv
module cfg_loader_regs
  import cfg_loader_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           cap_idx,
  input  logic [IW-1:0]  dip_sw,
  input  logic           consume,
  output logic [AW-1:0]  rdir_addr,
  output logic [AW-1:0]  sel_addr,
  output logic           stop_p,
  output logic           rdir_p,
  output logic           sel_p,
  output logic [IW-1:0]  cfg_idx
);

  localparam int NCFG = 1 << IW;

  logic [DW-1:0] rdir_hi_q, rdir_lo_q;
  logic [IW-1:0] idx_q;
  logic          stop_q, rdir_q, sel_q;
  logic          stop_d, rdir_d, sel_d;
  logic          wr_cmd, wr_hi, wr_lo;
  logic [NCFG-1:0][AW-1:0] tbl_flat;

  assign wr_cmd = host_we && (host_addr == HA_CMD);
  assign wr_hi  = host_we && (host_addr == HA_RDIR_HI);
  assign wr_lo  = host_we && (host_addr == HA_RDIR_LO);

  // Pending commands: a host set wins over a same-cycle consume.
  always_comb begin
    stop_d = stop_q | (wr_cmd & host_wdata[CB_STOP]);
    rdir_d = (rdir_q & ~consume) | (wr_cmd & host_wdata[CB_RDIR]);
    sel_d  = (sel_q  & ~consume) | (wr_cmd & host_wdata[CB_SELECT]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      rdir_q <= 1'b0;
      sel_q  <= 1'b0;
    end else begin
      stop_q <= stop_d;
      rdir_q <= rdir_d;
      sel_q  <= sel_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdir_hi_q <= '0;
      rdir_lo_q <= '0;
    end else begin
      if (wr_hi) rdir_hi_q <= host_wdata;
      if (wr_lo) rdir_lo_q <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (cap_idx) begin
      idx_q <= dip_sw;
    end
  end

  for (genvar k = 0; k < NCFG; k++) begin : g_tbl
    logic          hit_hi, hit_lo;
    logic [DW-1:0] hi_q, lo_q;

    assign hit_hi = host_we && (host_addr == HA_TABLE + HAW'(2 * k));
    assign hit_lo = host_we && (host_addr == HA_TABLE + HAW'(2 * k + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else begin
        if (hit_hi) hi_q <= host_wdata;
        if (hit_lo) lo_q <= host_wdata;
      end
    end

    assign tbl_flat[k] = {hi_q, lo_q};
  end

  always_comb begin
    host_rdata = '0;
    if (host_addr == HA_RDIR_HI) host_rdata = rdir_hi_q;
    if (host_addr == HA_RDIR_LO) host_rdata = rdir_lo_q;
    if (host_addr == HA_CMD)     host_rdata = {5'b0, rdir_q, sel_q, stop_q};
    if (host_addr == HA_INDEX)   host_rdata = DW'(idx_q);
    for (int k = 0; k < NCFG; k++) begin
      if (host_addr == HA_TABLE + HAW'(2 * k))     host_rdata = tbl_flat[k][AW-1:DW];
      if (host_addr == HA_TABLE + HAW'(2 * k + 1)) host_rdata = tbl_flat[k][DW-1:0];
    end
  end

  assign rdir_addr = {rdir_hi_q, rdir_lo_q};
  assign sel_addr  = tbl_flat[idx_q];
  assign stop_p    = stop_q;
  assign rdir_p    = rdir_q;
  assign sel_p     = sel_q;
  assign cfg_idx   = idx_q;

endmodule

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
  import cfg_loader_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  output logic          ee_req,
  output logic [AW-1:0] ee_addr,
  input  logic          ee_valid,
  input  logic [DW-1:0] ee_data,
  output logic          rf_we,
  output logic [AW-1:0] rf_addr,
  output logic [DW-1:0] rf_wdata,
  input  logic          stop_p,
  input  logic          rdir_p,
  input  logic          sel_p,
  input  logic [AW-1:0] rdir_addr,
  input  logic [AW-1:0] sel_addr,
  output logic          cap_idx,
  output logic          consume,
  output logic          booting
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  logic          data_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    data_d  = data_q;
    data_en = 1'b0;
    unique case (state_q)
      ST_BOOT: begin
        state_d = ST_REQ;
        addr_d  = '0;
      end
      ST_REQ: begin
        if (ee_valid) begin
          data_d  = ee_data;
          data_en = 1'b1;
          state_d = ST_WR;
        end
      end
      ST_WR: begin
        if (stop_p) begin
          state_d = ST_STOP;
        end else begin
          state_d = ST_REQ;
          if (rdir_p)     addr_d = rdir_addr;
          else if (sel_p) addr_d = sel_addr;
          else            addr_d = addr_q + 1'b1;
        end
      end
      ST_STOP: state_d = ST_STOP;
      default: state_d = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign ee_req   = (state_q == ST_REQ);
  assign ee_addr  = addr_q;
  assign rf_we    = (state_q == ST_WR);
  assign rf_addr  = addr_q;
  assign rf_wdata = data_q;
  assign consume  = (state_q == ST_WR);
  assign cap_idx  = (state_q == ST_BOOT);
  assign booting  = (state_q == ST_BOOT);

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfg_loader_pkg::*;
#(
  parameter int IW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [IW-1:0]  dip_sw,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           ee_req,
  output logic [AW-1:0]  ee_addr,
  input  logic           ee_valid,
  input  logic [DW-1:0]  ee_data,
  output logic           rf_we,
  output logic [AW-1:0]  rf_addr,
  output logic [DW-1:0]  rf_wdata
);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic          cap_idx, consume, booting;
  logic          stop_p, rdir_p, sel_p;
  logic [AW-1:0] rdir_addr, sel_addr;
  logic [IW-1:0] cfg_idx;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  cfg_loader_regs #(.IW(IW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cap_idx    (cap_idx),
    .dip_sw     (dip_sw),
    .consume    (consume),
    .rdir_addr  (rdir_addr),
    .sel_addr   (sel_addr),
    .stop_p     (stop_p),
    .rdir_p     (rdir_p),
    .sel_p      (sel_p),
    .cfg_idx    (cfg_idx)
  );

  cfg_loader_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .ee_req    (ee_req),
    .ee_addr   (ee_addr),
    .ee_valid  (ee_valid),
    .ee_data   (ee_data),
    .rf_we     (rf_we),
    .rf_addr   (rf_addr),
    .rf_wdata  (rf_wdata),
    .stop_p    (stop_p),
    .rdir_p    (rdir_p),
    .sel_p     (sel_p),
    .rdir_addr (rdir_addr),
    .sel_addr  (sel_addr),
    .cap_idx   (cap_idx),
    .consume   (consume),
    .booting   (booting)
  );

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk
  import cfg_loader_pkg::*;
#(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ee_req,
  input logic          ee_valid,
  input logic [AW-1:0] ee_addr,
  input logic          rf_we,
  input logic [AW-1:0] rf_addr,
  input logic          stop_p,
  input logic          rdir_p,
  input logic          sel_p,
  input logic [AW-1:0] rdir_addr,
  input logic [AW-1:0] sel_addr,
  input logic          booting,
  input logic [IW-1:0] cfg_idx
);

  assert_idx_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !booting |=> $stable(cfg_idx));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && !ee_valid |=> ee_req && $stable(ee_addr));

  assert_byte_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ee_req && ee_valid |=> rf_we);

  assert_we_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !stop_p && !rdir_p && !sel_p |=> ee_addr == $past(rf_addr) + 1'b1);

  assert_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !stop_p && rdir_p |=> ee_addr == $past(rdir_addr));

  assert_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && !stop_p && !rdir_p && sel_p |=> ee_addr == $past(sel_addr));

  assert_stopped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p && !ee_req |=> !ee_req);

endmodule

bind cfg_loader cfg_loader_chk #(.IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_s),
  .ee_req    (ee_req),
  .ee_valid  (ee_valid),
  .ee_addr   (ee_addr),
  .rf_we     (rf_we),
  .rf_addr   (rf_addr),
  .stop_p    (stop_p),
  .rdir_p    (rdir_p),
  .sel_p     (sel_p),
  .rdir_addr (rdir_addr),
  .sel_addr  (sel_addr),
  .booting   (booting),
  .cfg_idx   (cfg_idx)
);

// File: tb/cfg_loader_bench.sv
`timescale 1ns/1ps
module cfg_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  dip_sw;
  logic        host_we;
  logic [7:0]  host_addr, host_wdata, host_rdata;
  logic        ee_req, ee_valid;
  logic [15:0] ee_addr;
  logic [7:0]  ee_data;
  logic        rf_we;
  logic [15:0] rf_addr;
  logic [7:0]  rf_wdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // Bench-side model of the stream.
  logic [15:0] exp_addr;
  logic [15:0] m_rdir;
  logic [15:0] m_tbl [8];
  logic [2:0]  m_idx;
  bit m_stop, m_rdirp, m_selp, m_halted;

  always #4 clk = ~clk;

  cfg_loader #(.IW(3)) u_cfg_loader (
    .clk(clk), .rst_n(rst_n), .dip_sw(dip_sw),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ee_req(ee_req), .ee_addr(ee_addr), .ee_valid(ee_valid), .ee_data(ee_data),
    .rf_we(rf_we), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
  );

  function automatic logic [7:0] ebyte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [15:0] next_addr(input logic [15:0] cur);
    if (m_rdirp)     return m_rdir;
    else if (m_selp) return m_tbl[m_idx];
    else             return cur + 16'd1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    if (a == 8'h40) m_rdir[15:8] = d;
    if (a == 8'h41) m_rdir[7:0]  = d;
    if (a == 8'h42) begin
      if (d[0]) m_stop  = 1'b1;
      if (d[1]) m_selp  = 1'b1;
      if (d[2]) m_rdirp = 1'b1;
    end
    if (a >= 8'h50 && a <= 8'h5F) begin
      if (a[0]) m_tbl[a[3:1]][7:0]  = d;
      else      m_tbl[a[3:1]][15:8] = d;
    end
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a;
    #1 d = host_rdata;
  endtask

  task automatic do_byte(input int dly, input string req);
    int w = 0;
    while (!ee_req && w < 20) begin
      @(negedge clk);
      w++;
    end
    chk(ee_req, "R2 request", {31'd0, ee_req}, 32'd1);
    chk(ee_addr == exp_addr, req, {16'd0, ee_addr}, {16'd0, exp_addr});
    for (int i = 0; i < dly; i++) begin
      @(negedge clk);
      chk(ee_req && ee_addr == exp_addr, "R2 hold", {15'd0, ee_req, ee_addr}, {15'd0, 1'b1, exp_addr});
    end
    ee_valid = 1'b1;
    ee_data  = ebyte(exp_addr);
    @(negedge clk);
    ee_valid = 1'b0;
    chk(rf_we && rf_addr == exp_addr && rf_wdata == ebyte(exp_addr), "R3 write",
        {7'd0, rf_we, rf_addr, rf_wdata}, {7'd0, 1'b1, exp_addr, ebyte(exp_addr)});
    @(negedge clk);
    chk(!rf_we, "R3 single strobe", {31'd0, rf_we}, 32'd0);
    if (m_stop) begin
      m_halted = 1'b1;
    end else begin
      exp_addr = next_addr(exp_addr);
    end
    m_rdirp = 1'b0;
    m_selp  = 1'b0;
  endtask

  initial begin : main
    logic [7:0] d;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; dip_sw = 3'd5; host_we = 1'b0; host_addr = 8'h00; host_wdata = 8'h00;
    ee_valid = 1'b0; ee_data = 8'h00;
    m_rdir = '0; m_idx = 3'd5; m_stop = 0; m_rdirp = 0; m_selp = 0; m_halted = 0;
    for (int k = 0; k < 8; k++) m_tbl[k] = '0;
    exp_addr = 16'h0000;
    repeat (4) @(negedge clk);
    chk(!ee_req && !rf_we, "R1 reset quiet", {30'd0, ee_req, rf_we}, 32'd0);
    hread(8'h42, d);
    chk(d == 8'h00, "R8 reset cmd", {24'd0, d}, 32'd0);
    rst_n = 1'b1;

    // R1: first request at 0000h; later dip changes are not seen.
    do_byte(0, "R1 first address");
    dip_sw = 3'd2;
    hread(8'h43, d);
    chk(d == 8'h05, "R1 R9 index read", {24'd0, d}, 32'h05);
    hwrite(8'h43, 8'h07);
    hread(8'h43, d);
    chk(d == 8'h05, "R9 index read-only", {24'd0, d}, 32'h05);
    hread(8'h44, d);
    chk(d == 8'h00, "R9 unmapped 44h", {24'd0, d}, 32'h00);
    hread(8'hFF, d);
    chk(d == 8'h00, "R9 unmapped FFh", {24'd0, d}, 32'h00);

    // R4: sequential stepping with varied response delays.
    do_byte(2, "R4 step");
    do_byte(1, "R4 step");
    do_byte(3, "R4 step");

    // R5 / R10: redirect.
    hwrite(8'h40, 8'h12);
    hwrite(8'h41, 8'h34);
    hread(8'h40, d);
    chk(d == 8'h12, "R10 redirect hi", {24'd0, d}, 32'h12);
    hread(8'h41, d);
    chk(d == 8'h34, "R10 redirect lo", {24'd0, d}, 32'h34);
    hwrite(8'h42, 8'h04);
    hread(8'h42, d);
    chk(d == 8'h04, "R8 redirect pending", {24'd0, d}, 32'h04);
    do_byte(0, "R4 step");
    do_byte(0, "R5 redirect target");
    hread(8'h42, d);
    chk(d == 8'h00, "R8 redirect self-clear", {24'd0, d}, 32'h00);

    // R6 / R10: start table.
    for (int k = 0; k < 8; k++) begin
      hwrite(8'h50 + 8'(2 * k), 8'h80 + 8'(k));
      hwrite(8'h51 + 8'(2 * k), 8'h10 * 8'(k) + 8'h03);
    end
    for (int k = 0; k < 8; k++) begin
      hread(8'h50 + 8'(2 * k), d);
      chk(d == m_tbl[k][15:8], "R10 table hi", {24'd0, d}, {24'd0, m_tbl[k][15:8]});
      hread(8'h51 + 8'(2 * k), d);
      chk(d == m_tbl[k][7:0], "R10 table lo", {24'd0, d}, {24'd0, m_tbl[k][7:0]});
    end
    hwrite(8'h42, 8'h02);
    do_byte(1, "R5 step");
    do_byte(0, "R6 select target");

    // R8: redirect and select together, redirect wins, both clear.
    hwrite(8'h40, 8'hAB);
    hwrite(8'h41, 8'hCD);
    hwrite(8'h42, 8'h06);
    do_byte(0, "R6 step");
    do_byte(0, "R8 priority redirect");
    hread(8'h42, d);
    chk(d == 8'h00, "R8 both cleared", {24'd0, d}, 32'h00);
    do_byte(0, "R8 step after priority");

    // R9: reserved command bits ignored.
    hwrite(8'h42, 8'hF8);
    hread(8'h42, d);
    chk(d == 8'h00, "R9 reserved cmd bits", {24'd0, d}, 32'h00);
    do_byte(0, "R9 reserved no effect");

    // R4: wrap at FFFFh.
    hwrite(8'h40, 8'hFF);
    hwrite(8'h41, 8'hFF);
    hwrite(8'h42, 8'h04);
    do_byte(0, "R9 step");
    do_byte(2, "R5 redirect FFFFh");
    do_byte(0, "R4 wrap to 0000h");

    // Random mix of stepping and redirects.
    for (int it = 0; it < 60; it++) begin
      int r;
      r = $urandom_range(0, 5);
      if (r == 0) begin
        hwrite(8'h40, 8'($urandom));
        hwrite(8'h41, 8'($urandom));
        hwrite(8'h42, 8'h04);
      end else if (r == 1) begin
        hwrite(8'h5A, 8'($urandom));
        hwrite(8'h5B, 8'($urandom));
        hwrite(8'h42, 8'h02);
      end else if (r == 2) begin
        hwrite(8'h42, 8'($urandom) & 8'hFE);
      end
      do_byte($urandom_range(0, 3), "R4 R5 R6 random");
    end

    // R7: stop together with redirect; stop wins.
    hwrite(8'h42, 8'h05);
    hread(8'h42, d);
    chk(d == 8'h05, "R8 stop+redirect pending", {24'd0, d}, 32'h05);
    do_byte(1, "R7 outstanding read");
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ee_req || rf_we) chk(1'b0, "R7 stopped", {30'd0, ee_req, rf_we}, 32'd0);
    end
    chk(!ee_req, "R7 no request after stop", {31'd0, ee_req}, 32'd0);
    hread(8'h42, d);
    chk(d == 8'h01, "R7 R8 stop sticky", {24'd0, d}, 32'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule